// File: doc/BRIEF.md
# Shared-Memory Virtual-Channel Queue Bank

This block keeps several independent first-in first-out queues inside a single memory that has one read port and one write port. A typical use is one queue per virtual channel on a shared physical link. The memory is cut into equal, fixed-size regions, and each region belongs to one queue. Each queue keeps its own read pointer, its own write pointer and an occupancy count. The block reports the used and free slot counts of every queue, so an upstream sender can use them as credits.

Writes come in on a single valid/ready port that carries a queue index. `enq_ready` depends only on whether the addressed queue is full, so a sender may hold `enq_valid` and wait. A write that is offered while `enq_ready` is low is dropped and flagged. Each queue has its own consumer, and each consumer raises a per-queue request bit whenever it can take a word. A round-robin arbiter picks one eligible queue per cycle for the read port. A queue is eligible when its request bit is set and it is not empty. The memory output is registered. The chosen word appears one cycle later with a valid strobe and its queue index. A consumer that raises its request bit has promised to accept the word, so the output has no stall input.

Top module: `vc_queue_bank`

## Requirements
- R1: After reset every queue is empty. Each queue reports used 0 and free DEPTH. `out_valid`, `enq_err` and `deq_err` are low.
- R2: Each queue returns its accepted words in the order they were written. Queue q stores its words at memory addresses {q, pointer}, and each pointer wraps within the queue's DEPTH slots.
- R3: For each queue, used equals accepted writes minus granted reads, used never exceeds DEPTH, and free equals DEPTH minus used.
- R4: `enq_ready` is high exactly when the queue selected by `enq_qid` holds fewer than DEPTH words at the start of the cycle. If `enq_valid` is high while `enq_ready` is low, the write changes no queue state and is never returned, and `enq_err` is high in the next cycle.
- R5: A grant goes only to a queue whose `deq_req` bit is set and that is not empty at the start of the cycle. If any `deq_req` bit is set for an empty queue, `deq_err` is high in the next cycle, and that queue produces no output.
- R6: When a queue is granted in cycle t, `out_valid` is high in cycle t+1, with `out_qid` set to that queue and `out_data` set to its oldest word. With no grant, `out_valid` is low in the next cycle.
- R7: The arbiter grants in round-robin order. The search starts at the queue after the last one granted and wraps around. After reset the search starts at queue 0.
- R8: An accepted write and a grant to the same queue in the same cycle leave its used count unchanged. A queue can sustain one write and one read every cycle.
- R9: The queues are independent. Writes to one queue, reads from it, or a full or empty state in it change neither the contents nor the counts of any other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Write offer |
| enq_ready | output | 1 | Addressed queue has room |
| enq_qid | input | QW | Queue index of the write |
| enq_data | input | W | Word to write |
| enq_err | output | 1 | A write was offered to a full queue in the previous cycle |
| deq_req | input | NQ | Per-queue consumer ready |
| out_valid | output | 1 | Read word valid |
| out_qid | output | QW | Queue the read word came from |
| out_data | output | W | Read word |
| deq_err | output | 1 | An empty queue was requested in the previous cycle |
| q_used | output | NQ*CW | Used count per queue, queue q in bits [q*CW +: CW] |
| q_free | output | NQ*CW | Free count per queue, same packing |

## Verification
The bench fills one queue to the top and then drains it. This shows FIFO order, pointer wrap, and the boundary behaviour on both sides, where a write is refused at full and a request raises an error at empty. It then loads every queue and holds all request bits high, so the round-robin grant order is visible directly on `out_qid`. A phase that writes and reads the same queue in the same cycles separates a correct used count from one that counts only one of the two events. Finally, a sweep runs over every queue index, every request mask and both write states, followed by a long pseudo-random stretch. Both are checked each cycle against a per-queue arithmetic model, which shows that the queues stay independent.

// File: rtl/vcq_pkg.sv
package vcq_pkg;
  // Index width that is at least one bit.
  function automatic int unsigned bits_for(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vcq_sram.sv
module vcq_sram #(
  parameter int AW = 4,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vcq_rr_arb.sv
module vcq_rr_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!gnt_valid && req[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         last_q <= IW'(N - 1);
    else if (gnt_valid) last_q <= gnt_idx;
  end
endmodule

// File: rtl/vcq_qctrl.sv
module vcq_qctrl #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] used,
  output logic [CW-1:0] free,
  output logic          full,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      used <= '0;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (pop)  head <= head + PW'(1);
      case ({push, pop})
        2'b10:   used <= used + CW'(1);
        2'b01:   used <= used - CW'(1);
        default: used <= used;
      endcase
    end
  end

  assign full  = (used == CW'(DEPTH));
  assign empty = (used == '0);
  assign free  = CW'(DEPTH) - used;
endmodule

// File: rtl/vc_queue_bank.sv
module vc_queue_bank #(
  parameter  int NQ    = 4,
  parameter  int DEPTH = 4,
  parameter  int W     = 8,
  localparam int QW    = vcq_pkg::bits_for(NQ),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [QW-1:0]    enq_qid,
  input  logic [W-1:0]     enq_data,
  output logic             enq_err,
  input  logic [NQ-1:0]    deq_req,
  output logic             out_valid,
  output logic [QW-1:0]    out_qid,
  output logic [W-1:0]     out_data,
  output logic             deq_err,
  output logic [NQ*CW-1:0] q_used,
  output logic [NQ*CW-1:0] q_free
);
  localparam int PW = vcq_pkg::bits_for(DEPTH);
  localparam int AW = QW + PW;

  logic [PW-1:0] head_a [NQ];
  logic [PW-1:0] tail_a [NQ];
  logic [NQ-1:0] full_vec, empty_vec, push_vec, pop_vec;
  logic          enq_fire, gnt_valid;
  logic [QW-1:0] gnt_idx;

  assign enq_ready = ~full_vec[enq_qid];
  assign enq_fire  = enq_valid & enq_ready;

  vcq_rr_arb #(.N(NQ), .IW(QW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (deq_req & ~empty_vec),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign push_vec[q] = enq_fire  && (enq_qid == QW'(q));
    assign pop_vec[q]  = gnt_valid && (gnt_idx == QW'(q));

    vcq_qctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[q]),
      .pop   (pop_vec[q]),
      .head  (head_a[q]),
      .tail  (tail_a[q]),
      .used  (q_used[q*CW +: CW]),
      .free  (q_free[q*CW +: CW]),
      .full  (full_vec[q]),
      .empty (empty_vec[q])
    );
  end

  vcq_sram #(.AW(AW), .W(W)) u_mem (
    .clk   (clk),
    .we    (enq_fire),
    .waddr ({enq_qid, tail_a[enq_qid]}),
    .wdata (enq_data),
    .re    (gnt_valid),
    .raddr ({gnt_idx, head_a[gnt_idx]}),
    .rdata (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_qid   <= '0;
      enq_err   <= 1'b0;
      deq_err   <= 1'b0;
    end else begin
      out_valid <= gnt_valid;
      if (gnt_valid) out_qid <= gnt_idx;
      enq_err   <= enq_valid & ~enq_ready;
      deq_err   <= |(deq_req & empty_vec);
    end
  end
endmodule

// File: rtl/vcq_checker.sv
module vcq_checker #(
  parameter  int NQ    = 4,
  parameter  int DEPTH = 4,
  parameter  int W     = 8,
  localparam int QW    = vcq_pkg::bits_for(NQ),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic [NQ-1:0]    deq_req,
  input logic             enq_err,
  input logic             deq_err,
  input logic             out_valid,
  input logic [QW-1:0]    out_qid,
  input logic [NQ*CW-1:0] q_used
);
  for (genvar q = 0; q < NQ; q++) begin : g_bound
    a_r3_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_used[q*CW +: CW] <= CW'(DEPTH));
  end

  a_r4_enq_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    enq_err |-> $past(enq_valid));

  a_r5_deq_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    deq_err |-> $past(|deq_req));

  a_r6_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> |(($past(deq_req) >> out_qid) & NQ'(1)));
endmodule

bind vc_queue_bank vcq_checker #(.NQ(NQ), .DEPTH(DEPTH), .W(W)) u_vcq_checker (.*);

// File: tb/test_vc_queue_bank.sv
`timescale 1ns/1ps
module test_vc_queue_bank;
  localparam int NQ = 4, DEPTH = 4, W = 8, QW = 2, CW = 3;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             enq_valid = 1'b0, enq_ready;
  logic [QW-1:0]    enq_qid = '0;
  logic [W-1:0]     enq_data = '0;
  logic             enq_err, deq_err, out_valid;
  logic [NQ-1:0]    deq_req = '0;
  logic [QW-1:0]    out_qid;
  logic [W-1:0]     out_data;
  logic [NQ*CW-1:0] q_used, q_free;

  int tests = 0, fails = 0;
  bit done = 0;

  int mcnt [NQ];
  int mhead [NQ];
  logic [W-1:0] mq [NQ][DEPTH];
  int mlast;

  always #2.5 clk = ~clk;

  vc_queue_bank #(.NQ(NQ), .DEPTH(DEPTH), .W(W)) i_vc_queue_bank (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_qid(enq_qid), .enq_data(enq_data), .enq_err(enq_err),
    .deq_req(deq_req), .out_valid(out_valid), .out_qid(out_qid),
    .out_data(out_data), .deq_err(deq_err), .q_used(q_used), .q_free(q_free));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_counts(input string tag);
    for (int q = 0; q < NQ; q++) begin
      check(int'(q_used[q*CW +: CW]) == mcnt[q], tag, $sformatf("used q%0d", q),
            int'(q_used[q*CW +: CW]), mcnt[q]);
      check(int'(q_free[q*CW +: CW]) == DEPTH - mcnt[q], tag, $sformatf("free q%0d", q),
            int'(q_free[q*CW +: CW]), DEPTH - mcnt[q]);
    end
  endtask

  task automatic step(input logic ev, input int qid, input logic [W-1:0] d,
                      input logic [NQ-1:0] rq, input string tag);
    bit gv, de, acc;
    int g;
    logic [W-1:0] ed;
    enq_valid = ev; enq_qid = QW'(qid); enq_data = d; deq_req = rq;
    #1;
    check(enq_ready == (mcnt[qid] < DEPTH), "R4", "enq_ready",
          int'(enq_ready), int'(mcnt[qid] < DEPTH));
    gv = 0; g = 0; ed = '0;
    for (int off = 1; off <= NQ; off++) begin
      int k;
      k = (mlast + off) % NQ;
      if (!gv && rq[k] && mcnt[k] > 0) begin gv = 1; g = k; end
    end
    de = 0;
    for (int q = 0; q < NQ; q++) if (rq[q] && mcnt[q] == 0) de = 1;
    acc = ev && (mcnt[qid] < DEPTH);
    if (gv) ed = mq[g][mhead[g]];
    if (acc) mq[qid][(mhead[qid] + mcnt[qid]) % DEPTH] = d;
    if (gv) begin mhead[g] = (mhead[g] + 1) % DEPTH; mcnt[g]--; mlast = g; end
    if (acc) mcnt[qid]++;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == gv, tag, "out_valid", int'(out_valid), int'(gv));
    if (gv) begin
      check(int'(out_qid) == g, tag, "out_qid", int'(out_qid), g);
      check(out_data == ed, tag, "out_data", int'(out_data), int'(ed));
    end
    check(enq_err == (ev && !acc), tag, "enq_err", int'(enq_err), int'(ev && !acc));
    check(deq_err == de, tag, "deq_err", int'(deq_err), int'(de));
    check_counts(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    int dc;
    for (int q = 0; q < NQ; q++) begin mcnt[q] = 0; mhead[q] = 0; end
    mlast = NQ - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
    check(enq_err == 0 && deq_err == 0, "R1", "errors", int'({enq_err, deq_err}), 0);
    check_counts("R1");

    // R2/R3: fill queue 0, R4: extra write refused
    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'h10 + 8'(i), '0, "R3");
    step(1, 0, 8'h99, '0, "R4");
    // R2/R6: drain in order; R5: request on empty
    for (int i = 0; i < DEPTH; i++) step(0, 0, '0, 4'b0001, "R2");
    step(0, 0, '0, 4'b0001, "R5");
    step(0, 0, '0, 4'b1010, "R5");

    // R7: two words in every queue, all requesting
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < 2; i++) step(1, q, 8'(q * 16 + i), '0, "R9");
    for (int i = 0; i < 2 * NQ + 1; i++) step(0, 0, '0, 4'b1111, "R7");

    // R8: simultaneous write and read on queue 2
    step(1, 2, 8'h50, '0, "R8");
    for (int i = 0; i < 6; i++) step(1, 2, 8'h60 + 8'(i), 4'b0100, "R8");
    step(0, 0, '0, 4'b0100, "R6");

    // R9: sweep over queue index, request mask and write state
    dc = 0;
    for (int e = 0; e < 2; e++)
      for (int q = 0; q < NQ; q++)
        for (int m = 0; m < 16; m++) begin
          step(e[0], q, 8'(dc), 4'(m), "R9");
          dc++;
        end
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[6], int'(lfsr[2:1]), lfsr ^ 8'(i), lfsr[7:4], "R9");
    end
    step(0, 0, '0, '0, "R6");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule